// File: doc/BRIEF.md
# Bit-Serial Multiplier-Free 8-Point DCT

This block computes an eight-point one-dimensional forward DCT using no multipliers. A single-cycle start pulse captures eight signed samples. In the same edge, the block forms the four mirrored sums y[n]+y[7-n] and the four mirrored differences y[n]-y[7-n] for n = 0..3. These eight words then leave their shift registers one bit position per cycle, most significant bit first. The four sum bits form a 4-bit address that goes to the four even-index units. The four difference bits form the address for the four odd-index units.

Each output unit has a 16-word constant table and an accumulator. The table word at address a is the sum of the unit's four weights A[n] whose address bit n is set. The weights are 0.5·c(k)·cos((2n+1)kπ/16) in 12-bit fraction fixed point, with c(0) = 1/√2 and c(k) = 1 otherwise. On the first step, which carries the sign bits, the accumulator loads the negated table word. On every later step it doubles its value and adds the table word. After B = IW+1 steps, all eight rounded coefficients are registered together and done pulses for one cycle.

Top module: `da_dct8`

## Requirements
- R1: When start is high while busy is low, the eight samples on samp_in (sample n in bits [n*IW +: IW], signed) are captured, and busy reads high from the next cycle.
- R2: done is high for exactly one cycle. It rises VB = IW+1 cycles after the accepting edge, and busy is low in that same cycle.
- R3: Each even-index coefficient k (coef_out bits [k*OW +: OW], signed) is within ±2 of 0.5·c(k)·Σ y[n]·cos((2n+1)kπ/16), where c(0) = 1/√2 and c(k) = 1 otherwise.
- R4: Each odd-index coefficient meets the same ±2 bound. It is computed from the mirrored differences only.
- R5: A start while busy is high is ignored. No extra done appears, the running result is not disturbed, and busy stays high until done.
- R6: coef_out holds its value in every cycle in which done is low, whatever happens on samp_in.
- R7: Full-scale negative and alternating extreme inputs are correct within ±2. This requires the sign-bit step to subtract and not add.
- R8: After synchronous reset, busy and done are low and every coefficient reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture samples and begin a transform |
| samp_in | input | 8*IW | Eight signed samples, sample n at [n*IW +: IW] |
| coef_out | output | 8*OW | Eight signed coefficients, coefficient k at [k*OW +: OW] |
| busy | output | 1 | Transform in progress |
| done | output | 1 | One-cycle pulse when coef_out is updated |

## Verification
A fault in a mirrored sum or difference register corrupts all four coefficients of the same parity. A fault in one table word corrupts only its own coefficient, and only for inputs whose bit pattern reaches that address. A sign step that adds instead of subtracting shows up mainly on negative and full-scale inputs. A step counter that is off by one moves done away from VB cycles and scales every result by two. All of these faults become visible at the first done pulse after the faulty transform starts, so VB+1 cycles after start. The reference is computed in floating point, independently of the table constants.

// File: rtl/da_dct_pkg.sv
package da_dct_pkg;
  localparam int CF = 12;
  localparam int NPT = 8;
  localparam int NHALF = 4;

  function automatic int half_cos_tab(input int m);
    case (m)
      0: return 2048;
      1: return 2009;
      2: return 1892;
      3: return 1703;
      4: return 1448;
      5: return 1138;
      6: return 784;
      7: return 400;
      default: return 0;
    endcase
  endfunction

  function automatic int weight_q(input int k, input int n);
    int m;
    if (k == 0) return 1448;
    m = ((2 * n + 1) * k) % 32;
    if (m > 16) m = 32 - m;
    if (m > 8) return -half_cos_tab(16 - m);
    return half_cos_tab(m);
  endfunction

  function automatic int rom_word(input int k, input int addr);
    int s;
    s = 0;
    for (int n = 0; n < NHALF; n++)
      if (((addr >> n) & 1) == 1) s += weight_q(k, n);
    return s;
  endfunction
endpackage

// File: rtl/da_seq.sv
module da_seq #(
  parameter int VB = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic load,
  output logic step,
  output logic first,
  output logic last,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(VB);
  logic [CW-1:0] cnt;

  assign load  = start && !busy;
  assign step  = busy;
  assign first = busy && (cnt == '0);
  assign last  = busy && (cnt == CW'(VB - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
    end else begin
      done <= last;
      if (load) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
        if (last) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/da_presum.sv
module da_presum #(
  parameter int IW = 8,
  parameter int VB = IW + 1
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              load,
  input  logic                              shift,
  input  logic [da_dct_pkg::NPT*IW-1:0]     samp,
  output logic [da_dct_pkg::NHALF-1:0]      sum_bits,
  output logic [da_dct_pkg::NHALF-1:0]      dif_bits
);
  import da_dct_pkg::*;

  logic signed [VB-1:0] sum_sr [NHALF];
  logic signed [VB-1:0] dif_sr [NHALF];

  for (genvar n = 0; n < NHALF; n++) begin : g_lane
    logic signed [IW-1:0] ya, yb;
    logic signed [VB-1:0] sa, sb;
    assign ya = samp[n*IW +: IW];
    assign yb = samp[(NPT-1-n)*IW +: IW];
    assign sa = VB'(ya);
    assign sb = VB'(yb);

    always_ff @(posedge clk) begin
      if (rst) begin
        sum_sr[n] <= '0;
        dif_sr[n] <= '0;
      end else if (load) begin
        sum_sr[n] <= sa + sb;
        dif_sr[n] <= sa - sb;
      end else if (shift) begin
        sum_sr[n] <= {sum_sr[n][VB-2:0], 1'b0};
        dif_sr[n] <= {dif_sr[n][VB-2:0], 1'b0};
      end
    end

    assign sum_bits[n] = sum_sr[n][VB-1];
    assign dif_bits[n] = dif_sr[n][VB-1];
  end
endmodule

// File: rtl/da_rac.sv
module da_rac #(
  parameter int K  = 0,
  parameter int VB = 9,
  parameter int OW = 12
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         step,
  input  logic                         first,
  input  logic                         last,
  input  logic [da_dct_pkg::NHALF-1:0] addr,
  output logic signed [OW-1:0]         coef
);
  import da_dct_pkg::*;

  localparam int RW = CF + 3;
  localparam int AW = RW + VB + 1;
  localparam logic signed [AW-1:0] HALF = AW'(1) <<< (CF - 1);

  logic signed [RW-1:0] rom_q;
  logic signed [AW-1:0] rom_x, acc, acc_nx, acc_rnd;

  always_comb begin
    rom_q = RW'(rom_word(K, int'(addr)));
  end

  assign rom_x   = AW'(rom_q);
  assign acc_nx  = first ? -rom_x : ((acc <<< 1) + rom_x);
  assign acc_rnd = acc_nx + HALF;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc  <= '0;
      coef <= '0;
    end else if (step) begin
      acc <= acc_nx;
      if (last) coef <= OW'(acc_rnd >>> CF);
    end
  end
endmodule

// File: rtl/da_dct8.sv
module da_dct8 #(
  parameter int IW = 8,
  parameter int VB = IW + 1,
  parameter int OW = IW + 4
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              start,
  input  logic [da_dct_pkg::NPT*IW-1:0]     samp_in,
  output logic [da_dct_pkg::NPT*OW-1:0]     coef_out,
  output logic                              busy,
  output logic                              done
);
  import da_dct_pkg::*;

  logic load, step, first, last;
  logic [NHALF-1:0] sum_bits, dif_bits;

  da_seq #(.VB(VB)) u_seq (
    .clk(clk), .rst(rst), .start(start), .load(load), .step(step),
    .first(first), .last(last), .busy(busy), .done(done)
  );

  da_presum #(.IW(IW), .VB(VB)) u_pre (
    .clk(clk), .rst(rst), .load(load), .shift(step), .samp(samp_in),
    .sum_bits(sum_bits), .dif_bits(dif_bits)
  );

  for (genvar k = 0; k < NPT; k++) begin : g_rac
    logic [NHALF-1:0] bus;
    logic signed [OW-1:0] c;
    if (k % 2 == 0) begin : g_even
      assign bus = sum_bits;
    end else begin : g_odd
      assign bus = dif_bits;
    end
    da_rac #(.K(k), .VB(VB), .OW(OW)) u_rac (
      .clk(clk), .rst(rst), .step(step), .first(first), .last(last),
      .addr(bus), .coef(c)
    );
    assign coef_out[k*OW +: OW] = c;
  end
endmodule

// File: rtl/da_dct8_chk.sv
module da_dct8_chk #(
  parameter int VB = 9,
  parameter int OW = 12
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  start,
  input logic                  busy,
  input logic                  done,
  input logic [8*OW-1:0]       coef_out
);
  logic [7:0] bcnt;

  always_ff @(posedge clk) begin
    if (rst) bcnt <= '0;
    else if (start && !busy) bcnt <= '0;
    else if (busy) bcnt <= bcnt + 1'b1;
  end

  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst) (start && !busy) |=> busy); // R1
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R2
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst) done |-> !busy); // R2
  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (rst) done |-> (bcnt == 8'(VB))); // R2
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst) busy |=> (busy || done)); // R5
  AST_COEF_HOLD: assert property (@(posedge clk) disable iff (rst) !done |=> (done || $stable(coef_out))); // R6
endmodule

bind da_dct8 da_dct8_chk #(.VB(VB), .OW(OW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .coef_out(coef_out)
);

// File: tb/sim_da_dct8.sv
`timescale 1ns/1ps
module sim_da_dct8;
  localparam int IW = 8;
  localparam int VB = IW + 1;
  localparam int OW = IW + 4;
  localparam real PI = 3.14159265358979323846;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [8*IW-1:0] samp = '0;
  logic [8*OW-1:0] coef_out;
  logic busy, done;

  int n_tests = 0;
  int n_fail = 0;
  int cyc = 0;
  int dones_seen = 0;
  int pushed = 0;
  real qx[$];
  int  qc[$];
  bit  qe[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  da_dct8 #(.IW(IW), .VB(VB), .OW(OW)) u0 (
    .clk(clk), .rst(rst), .start(start), .samp_in(samp),
    .coef_out(coef_out), .busy(busy), .done(done)
  );

  function automatic real ref_x(input logic [8*IW-1:0] v, input int k);
    real s;
    s = 0.0;
    for (int n = 0; n < 8; n++)
      s += $itor($signed(v[n*IW +: IW])) * $cos((2.0 * n + 1.0) * k * PI / 16.0);
    s = 0.5 * s;
    if (k == 0) s = s / $sqrt(2.0);
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input string what, input real act, input real exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0f expected %0f", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  task automatic drive(input logic [8*IW-1:0] v, input bit ext);
    @(negedge clk);
    samp = v;
    start = 1'b1;
    for (int k = 0; k < 8; k++) qx.push_back(ref_x(v, k));
    qc.push_back(cyc + 1 + VB);
    qe.push_back(ext);
    pushed++;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R1", "busy after start", real'(busy), 1.0);
  endtask

  task automatic wait_idle();
    while (qc.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (!rst && done) begin
      dones_seen++;
      if (qc.size() == 0) begin
        check(1'b0, "R5", "unexpected done", 1.0, 0.0);
      end else begin
        int ec;
        bit ex;
        ec = qc.pop_front();
        ex = qe.pop_front();
        check(cyc == ec, "R2", "done cycle", real'(cyc), real'(ec));
        check(busy == 1'b0, "R2", "busy low at done", real'(busy), 0.0);
        for (int k = 0; k < 8; k++) begin
          real e, a;
          e = qx.pop_front();
          a = $itor($signed(coef_out[k*OW +: OW]));
          if (ex)
            check((a - e <= 2.0) && (e - a <= 2.0), "R7", $sformatf("extreme coef %0d", k), a, e);
          else if (k % 2 == 0)
            check((a - e <= 2.0) && (e - a <= 2.0), "R3", $sformatf("even coef %0d", k), a, e);
          else
            check((a - e <= 2.0) && (e - a <= 2.0), "R4", $sformatf("odd coef %0d", k), a, e);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    check(1'b0, "WDOG", "watchdog expired", 0.0, 1.0);
    finish_run();
  end

  initial begin
    logic [8*IW-1:0] v;
    logic [8*OW-1:0] held;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(busy == 1'b0, "R8", "busy after reset", real'(busy), 0.0);
    check(done == 1'b0, "R8", "done after reset", real'(done), 0.0);
    check(coef_out == '0, "R8", "coef after reset", 0.0, 0.0);

    for (int n = 0; n < 8; n++) v[n*IW +: IW] = IW'(n * 10);
    drive(v, 1'b0); wait_idle();
    for (int n = 0; n < 8; n++) v[n*IW +: IW] = IW'(50);
    drive(v, 1'b0); wait_idle();
    for (int n = 0; n < 8; n++) v[n*IW +: IW] = (n % 2 == 0) ? IW'(100) : IW'(-100);
    drive(v, 1'b0); wait_idle();
    for (int n = 0; n < 8; n++) v[n*IW +: IW] = IW'(-128);
    drive(v, 1'b1); wait_idle();
    for (int n = 0; n < 8; n++) v[n*IW +: IW] = (n % 2 == 0) ? IW'(127) : IW'(-128);
    drive(v, 1'b1); wait_idle();
    for (int n = 0; n < 8; n++) v[n*IW +: IW] = (n < 4) ? IW'(-128) : IW'(127);
    drive(v, 1'b1); wait_idle();
    for (int r = 0; r < 6; r++) begin
      for (int n = 0; n < 8; n++) v[n*IW +: IW] = IW'($urandom_range(255));
      drive(v, 1'b0); wait_idle();
    end

    // R5: start during busy with other samples must be ignored
    for (int n = 0; n < 8; n++) v[n*IW +: IW] = IW'(7 * n - 20);
    drive(v, 1'b0);
    @(negedge clk);
    samp = ~v;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    repeat (VB + 4) @(negedge clk);
    check(dones_seen == pushed, "R5", "done count", real'(dones_seen), real'(pushed));
    check(busy == 1'b0, "R5", "idle after ignored start", real'(busy), 0.0);

    // R6: outputs hold while no new result
    held = coef_out;
    for (int r = 0; r < 12; r++) begin
      @(negedge clk);
      samp = {8{8'(r * 37)}};
    end
    check(coef_out == held, "R6", "coef hold", 0.0, 0.0);

    finish_run();
  end
endmodule